// File: doc/BRIEF.md
# Invertible-Set Read Decoder

This block is the read side of a stuck-at fault masking scheme for resistive memory. A protected block is stored as a grid of cells. Each row and each column has a small saturating counter. When the block was written, the encoder inverted nested subsets of the grid until every cell stuck at the wrong value lay in an inverted region. On a read, the decoder takes the raw cell bits and the stored counters and recovers the original data.

For each cell, the decoder takes the smaller of the cell's row counter and column counter. If that minimum is odd, the decoder inverts the raw bit. If it is even, the bit passes through unchanged. The decode is combinational across the whole grid. One output register gives a fixed latency of one clock. A block is offered with `in_valid`, and its decoded form appears with `out_valid` on the next cycle. A new block may be offered in every cycle.

Top module: `inv_set_decoder`

## Requirements
- R1: While `rst_n` is low, and in the cycle after a clock edge that saw it low, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is high in exactly the cycles that follow a clock edge at which `in_valid` was high, so back-to-back blocks come out back to back.
- R3: Bit `r*COLS + c` of `in_raw` and `out_data` is the cell at row r and column c. The counter for row r is `in_row_cnt[r*CNT_W +: CNT_W]`, and the counter for column c is `in_col_cnt[c*CNT_W +: CNT_W]`.
- R4: A cell whose minimum counter is odd is output as the inverse of its raw bit.
- R5: A cell whose minimum counter is even, including zero, is output equal to its raw bit.
- R6: When every counter is zero, `out_data` equals `in_raw` bit for bit.
- R7: After a clock edge at which `in_valid` was low, `out_data` keeps its previous value.
- R8: Suppose a block is encoded by iterative inversion, with one, two or three cells stuck at either value. Decoding the stored grid together with the final counters returns the original data.
- R9: Counters at their full value (all ones, 3 for CNT_W = 2) are decoded like any other odd minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw block and counters are present |
| in_raw | input | ROWS*COLS | Raw cell bits in row-major order |
| in_row_cnt | input | ROWS*CNT_W | Per-row counters, row 0 in the low bits |
| in_col_cnt | input | COLS*CNT_W | Per-column counters, column 0 in the low bits |
| out_valid | output | 1 | Decoded block is present |
| out_data | output | ROWS*COLS | Decoded block in row-major order |

## Verification
Two things can happen in the same cycle. The decoder can present the decoded form of one block while it captures the next block, and it can hold a finished result while `in_valid` is low. The bench drives runs of back-to-back blocks with different counters, separated by idle gaps. A behavioural model advances at every clock edge and is compared with both outputs on every cycle. This catches any result that is dropped, repeated or overwritten. Round-trip blocks are produced by an encoder in the bench that works on fault maps, and their decoded output is judged against the original data.

// File: rtl/inv_set_decoder.sv
module inv_set_decoder #(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int CNT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [ROWS*COLS-1:0]     in_raw,
  input  logic [ROWS*CNT_W-1:0]    in_row_cnt,
  input  logic [COLS*CNT_W-1:0]    in_col_cnt,
  output logic                     out_valid,
  output logic [ROWS*COLS-1:0]     out_data
);
  localparam int NBITS = ROWS * COLS;

  logic [NBITS-1:0] flip;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [CNT_W-1:0] rcnt;
    assign rcnt = in_row_cnt[r*CNT_W +: CNT_W];
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [CNT_W-1:0] ccnt;
      logic [CNT_W-1:0] lo;
      assign ccnt = in_col_cnt[c*CNT_W +: CNT_W];
      assign lo   = (rcnt < ccnt) ? rcnt : ccnt;
      assign flip[r*COLS + c] = lo[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_raw ^ flip;
    end
  end
endmodule

// File: rtl/inv_set_decoder_chk.sv
module inv_set_decoder_chk #(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int CNT_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [ROWS*COLS-1:0]  in_raw,
  input logic [ROWS*CNT_W-1:0] in_row_cnt,
  input logic [COLS*CNT_W-1:0] in_col_cnt,
  input logic                  out_valid,
  input logic [ROWS*COLS-1:0]  out_data
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_data == '0));

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> $stable(out_data));

  a_r6_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(in_row_cnt) == '0 && $past(in_col_cnt) == '0)
      |-> (out_data == $past(in_raw)));

  a_r9_full_invert: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(&in_row_cnt) && $past(&in_col_cnt))
      |-> (out_data == ~$past(in_raw)));
endmodule

bind inv_set_decoder inv_set_decoder_chk #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
  .in_row_cnt(in_row_cnt), .in_col_cnt(in_col_cnt),
  .out_valid(out_valid), .out_data(out_data));

// File: tb/inv_set_decoder_tb_top.sv
`timescale 1ns/1ps
module inv_set_decoder_tb_top;
  localparam int ROWS = 4, COLS = 8, CNT_W = 2;
  localparam int N = ROWS * COLS;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [N-1:0] in_raw = '0;
  logic [ROWS*CNT_W-1:0] in_row_cnt = '0;
  logic [COLS*CNT_W-1:0] in_col_cnt = '0;
  logic out_valid;
  logic [N-1:0] out_data;

  always #5 clk = ~clk;

  inv_set_decoder #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
    .in_row_cnt(in_row_cnt), .in_col_cnt(in_col_cnt),
    .out_valid(out_valid), .out_data(out_data));

  int checks = 0, fails = 0;
  string tag = "R1";
  logic [N-1:0] cur_orig = '0;
  bit cur_rt = 0;

  // behavioural reference state
  bit exp_valid = 0;
  logic [N-1:0] exp_data = '0;
  logic [N-1:0] exp_orig = '0;
  bit exp_rt = 0;
  bit done = 0;

  function automatic logic [N-1:0] model(logic [N-1:0] raw, logic [ROWS*CNT_W-1:0] rv,
                                         logic [COLS*CNT_W-1:0] cv);
    logic [N-1:0] o;
    for (int i = 0; i < N; i++) begin
      int r, c, a, b, m;
      r = i / COLS; c = i % COLS;
      a = int'(rv[r*CNT_W +: CNT_W]); b = int'(cv[c*CNT_W +: CNT_W]);
      m = (a < b) ? a : b;
      o[i] = (m % 2 == 1) ? ~raw[i] : raw[i];
    end
    return o;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 0; exp_data <= '0; exp_rt <= 0;
    end else begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_data <= model(in_raw, in_row_cnt, in_col_cnt);
        exp_orig <= cur_orig;
        exp_rt   <= cur_rt;
      end
    end
  end

  task automatic check(string t, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check({tag, " R2 valid"}, {{(N-1){1'b0}}, out_valid}, {{(N-1){1'b0}}, exp_valid});
    check({tag, " data"}, out_data, exp_data);
    if (exp_valid && exp_rt) check("R8 round trip", out_data, exp_orig);
  end

  task automatic drive(bit v, logic [N-1:0] raw, logic [ROWS*CNT_W-1:0] rv,
                       logic [COLS*CNT_W-1:0] cv);
    @(negedge clk); #1;
    in_valid = v; in_raw = raw; in_row_cnt = rv; in_col_cnt = cv;
  endtask

  // encoder over a fault map; returns 1 on success
  task automatic encode(input logic [N-1:0] data, input logic [N-1:0] smask,
                        input logic [N-1:0] sval, output logic [N-1:0] stored,
                        output logic [ROWS*CNT_W-1:0] rv, output logic [COLS*CNT_W-1:0] cv,
                        output bit ok);
    int rc[ROWS], cc[COLS];
    bit wrong_r[ROWS], wrong_c[COLS];
    bit any;
    foreach (rc[i]) rc[i] = 0;
    foreach (cc[i]) cc[i] = 0;
    ok = 0;
    for (int it = 0; it <= CMAX; it++) begin
      any = 0;
      foreach (wrong_r[i]) wrong_r[i] = 0;
      foreach (wrong_c[i]) wrong_c[i] = 0;
      for (int i = 0; i < N; i++) begin
        int m; bit want;
        m = (rc[i/COLS] < cc[i%COLS]) ? rc[i/COLS] : cc[i%COLS];
        want = data[i] ^ (m % 2 == 1);
        stored[i] = smask[i] ? sval[i] : want;
        if (stored[i] != want) begin
          any = 1; wrong_r[i/COLS] = 1; wrong_c[i%COLS] = 1;
        end
      end
      if (!any) begin ok = 1; break; end
      if (it == CMAX) break;
      foreach (rc[i]) if (wrong_r[i]) rc[i]++;
      foreach (cc[i]) if (wrong_c[i]) cc[i]++;
    end
    foreach (rc[i]) rv[i*CNT_W +: CNT_W] = CNT_W'(rc[i]);
    foreach (cc[i]) cv[i*CNT_W +: CNT_W] = CNT_W'(cc[i]);
  endtask

  function automatic logic [N-1:0] rnd();
    logic [N-1:0] v;
    for (int i = 0; i < N; i += 32) v[i +: 32] = $urandom;
    return v;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] d, st, sm, sv;
    logic [ROWS*CNT_W-1:0] rv;
    logic [COLS*CNT_W-1:0] cv;
    bit ok;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {{(N-1){1'b0}}, out_valid}, '0);
    check("R1 reset data", out_data, '0);
    rst_n = 1;

    tag = "R6";
    for (int k = 0; k < 6; k++) drive(1, rnd(), '0, '0);
    tag = "R4 R9";
    for (int k = 0; k < 4; k++) drive(1, rnd(), '1, '1);
    tag = "R7";
    drive(0, rnd(), '1, '0);
    drive(0, rnd(), '0, '1);
    tag = "R3";
    for (int r = 0; r < ROWS; r++) begin
      rv = '0; rv[r*CNT_W] = 1'b1;
      drive(1, '0, rv, '1);
    end
    for (int c = 0; c < COLS; c++) begin
      cv = '0; cv[c*CNT_W +: CNT_W] = CNT_W'(3);
      drive(1, rnd(), '1, cv);
    end
    tag = "R4 R5";
    for (int k = 0; k < 40; k++) begin
      rv = ROWS*CNT_W'($urandom); cv = COLS*CNT_W'($urandom);
      drive((k % 5) != 4, rnd(), rv, cv);
    end
    tag = "R2 R7";
    drive(0, '1, '1, '1);

    tag = "R8";
    for (int k = 0; k < 60; k++) begin
      int nf;
      d = rnd(); sm = '0; sv = rnd();
      nf = 1 + (k % 3);
      for (int f = 0; f < nf; f++) sm[$urandom_range(N-1)] = 1'b1;
      encode(d, sm, sv, st, rv, cv, ok);
      if (!ok) begin
        checks++; fails++;
        $display("FAIL R8 encoder: actual stuck expected masked");
      end
      @(negedge clk); #1;
      cur_orig = d; cur_rt = ok;
      in_valid = 1; in_raw = st; in_row_cnt = rv; in_col_cnt = cv;
    end
    drive(0, '0, '0, '0);
    cur_rt = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 0; tag = "R1";
    @(negedge clk);
    check("R1 mid reset valid", {{(N-1){1'b0}}, out_valid}, '0);
    check("R1 mid reset data", out_data, '0);
    finish_run();
  end
endmodule